// File: doc/BRIEF.md
# Serial Clock Generator with Selectable Divide Law

This block makes the serial clock for a synchronous serial port from the system clock. A law-select input chooses how the 8-bit divider field is read. The power-of-two law uses the low four bits of the field, N, and divides by 2^(N+1). The linear law uses all eight bits and divides by 2 × (N+1). The clock polarity input sets the level the serial clock rests at between bursts. While the core enable is low, the output is forced low whatever the polarity.

A shifter next to this block asks for clocking by holding `run` high. It then receives the clock level and two single-cycle strobes. `lead_edge` marks each move of the serial clock away from its idle level and `trail_edge` marks each return to it, so the shifter can sample and launch data on the edges its phase setting picks. Each half period runs to completion. Dropping `run` therefore never shortens a pulse, and a new divider value only takes effect when the counter next reloads.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `law_sel` = 0 (power-of-two law), each half period of `sclk` lasts 2^N system cycles, where N = `div_field[3:0]`. Bits 7:4 of `div_field` have no effect.
- R2: With `law_sel` = 1 (linear law), each half period of `sclk` lasts N+1 system cycles, where N = `div_field[7:0]`.
- R3: While `enable` is 1 and the generator is idle, `sclk` equals `cpol`, and neither strobe is asserted.
- R4: While `enable` is 0, `sclk` is 0 and neither strobe is asserted, whatever `run` and `cpol` are. The generator returns to idle.
- R5: `lead_edge` is high for exactly one cycle, in the cycle where `sclk` first shows the non-idle level (not equal to `cpol`). `trail_edge` is high for exactly one cycle, in the cycle where `sclk` first shows the idle level again. The two strobes are never high together.
- R6: Suppose `run` is first sampled high at a rising clock edge while the generator is idle. `lead_edge` then appears one half period later. Once `run` is low, the clock stops only at the end of a half period: a non-idle phase that has begun ends with its `trail_edge` after a full half period. A low phase that ends with `run` low produces no further `lead_edge`.
- R7: A change to `law_sel` or `div_field` during a half period does not alter that half period. The new length applies from the next reload.
- R8: After an asynchronous active-low reset, `sclk`, `lead_edge` and `trail_edge` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Core enable; low forces the serial clock low |
| law_sel | input | 1 | Divide law: 0 power-of-two, 1 linear |
| div_field | input | 8 | Divider value N |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | Request for the clock to run |
| sclk | output | 1 | Serial clock level |
| lead_edge | output | 1 | One-cycle strobe when sclk leaves its idle level |
| trail_edge | output | 1 | One-cycle strobe when sclk returns to its idle level |

## Verification
On every cycle, the assertions check the following. The strobes are exclusive and last one cycle. Each strobe agrees with the `sclk` level beside it. Disabling the core silences both strobes. The half-period counter reloads the value computed on the cycle it loads. Only the bench scenarios can show the actual half-period lengths under each law across the sweep of N, and that the upper field bits are ignored under the power-of-two law. The same holds for the latency from the `run` request to the first edge, the clean finish after `run` drops in either phase, and a divider change landing only at the next reload.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned EXP_W   = 4;
    localparam int unsigned POW_W   = (1 << EXP_W);
    localparam int unsigned CNT_W   = (POW_W > FIELD_W + 1) ? POW_W : FIELD_W + 1;

    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } law_e;

    typedef struct packed {
        logic active;
        logic phase;
        logic lead;
        logic trail;
    } gen_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;
endpackage

// File: rtl/sclk_half_calc.sv
module sclk_half_calc
    import spi_sclk_pkg::*;
#(
    parameter int unsigned F_W = FIELD_W,
    parameter int unsigned E_W = EXP_W,
    parameter int unsigned C_W = CNT_W
) (
    input  logic           law_sel,
    input  logic [F_W-1:0] div_field,
    output logic [C_W-1:0] reload_val
);
    // reload_val is the half-period length minus one
    logic [C_W-1:0] pow_len;
    logic [C_W-1:0] lin_len;

    always_comb begin
        pow_len = C_W'(1) << div_field[E_W-1:0];
        lin_len = C_W'(div_field);
        if (law_e'(law_sel) == LAW_POW2) begin
            reload_val = pow_len - C_W'(1);
        end else begin
            reload_val = lin_len;
        end
    end
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer
    import spi_sclk_pkg::*;
#(
    parameter int unsigned C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           start,
    input  logic           count,
    input  logic [C_W-1:0] reload_val,
    output logic           tick
);
    logic [C_W-1:0] cnt_d;
    logic [C_W-1:0] cnt_q;

    assign tick = count && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = reload_val;
        end else if (count) begin
            if (cnt_q == '0) begin
                cnt_d = reload_val;
            end else begin
                cnt_d = cnt_q - C_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: a half period begins with exactly the length computed when it was loaded
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (cnt_q == $past(reload_val)));

    // R6: a start loads the first half period
    assert_start_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               law_sel,
    input  logic [FIELD_W-1:0] div_field,
    input  logic               cpol,
    input  logic               run,
    output logic               sclk,
    output logic               lead_edge,
    output logic               trail_edge
);
    gen_state_t       st_d;
    gen_state_t       st_q;
    logic [CNT_W-1:0] reload_val;
    logic             tick;
    logic             t_clear;
    logic             t_start;
    logic             t_count;

    sclk_half_calc #(
        .F_W (FIELD_W),
        .E_W (EXP_W),
        .C_W (CNT_W)
    ) u_calc (
        .law_sel    (law_sel),
        .div_field  (div_field),
        .reload_val (reload_val)
    );

    assign t_clear = !enable;
    assign t_start = enable && !st_q.active && run;
    assign t_count = enable && st_q.active;

    sclk_half_timer #(
        .C_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (t_clear),
        .start      (t_start),
        .count      (t_count),
        .reload_val (reload_val),
        .tick       (tick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (!st_q.active) begin
            if (run) begin
                st_d.active = 1'b1;
            end
        end else if (tick) begin
            if (st_q.phase) begin
                st_d.phase = 1'b0;
                st_d.trail = 1'b1;
                if (!run) begin
                    st_d.active = 1'b0;
                end
            end else if (run) begin
                st_d.phase = 1'b1;
                st_d.lead  = 1'b1;
            end else begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk       = enable && (cpol ^ st_q.phase);
    assign lead_edge  = st_q.lead;
    assign trail_edge = st_q.trail;

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_edge && trail_edge));

    assert_lead_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_edge |=> !lead_edge);

    assert_trail_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trail_edge |=> !trail_edge);

    assert_lead_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_edge && enable) |-> (sclk != cpol));

    assert_trail_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_edge && enable) |-> (sclk == cpol));

    assert_quiet_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!lead_edge && !trail_edge));
endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       law_sel = 1'b0;
    logic [7:0] div_field = 8'd0;
    logic       cpol = 1'b0;
    logic       run = 1'b0;
    logic       sclk;
    logic       lead_edge;
    logic       trail_edge;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_sclk_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .law_sel    (law_sel),
        .div_field  (div_field),
        .cpol       (cpol),
        .run        (run),
        .sclk       (sclk),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // count negedges until the chosen strobe is seen, bounded by lim
    task automatic wait_strobe(input bit want_lead, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_lead ? lead_edge : trail_edge) && n < lim);
    endtask

    task automatic quiet_window(input string req, input int cycles, input int exp_sclk);
        int hits = 0;
        int wrong = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (lead_edge || trail_edge) hits++;
            if (int'(sclk) != exp_sclk) wrong++;
        end
        check_eq(req, "strobes in quiet window", hits, 0);
        check_eq(req, "sclk off level in quiet window", wrong, 0);
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable = 1'b0;
        run    = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_cfg(input string req, input logic law, input logic [7:0] fld,
                           input logic pol, input int h);
        int n;
        go_idle();
        law_sel   = law;
        div_field = fld;
        cpol      = pol;
        enable    = 1'b1;
        run       = 1'b1;
        wait_strobe(1'b1, 2 * h + 8, n);
        check_eq("R6", "latency to first lead", n, h + 1);
        check_eq("R5", "sclk at lead", int'(sclk), int'(!pol));
        wait_strobe(1'b0, 2 * h + 8, n);
        check_eq(req, "high half length", n, h);
        check_eq("R5", "sclk at trail", int'(sclk), int'(pol));
        wait_strobe(1'b1, 2 * h + 8, n);
        check_eq(req, "low half length", n, h);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R8: reset state
        check_eq("R8", "sclk in reset", int'(sclk), 0);
        check_eq("R8", "strobes in reset", int'(lead_edge) + int'(trail_edge), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R8", "sclk after reset", int'(sclk), 0);

        // R3: idle level follows polarity
        enable = 1'b1;
        cpol   = 1'b1;
        quiet_window("R3", 10, 1);
        cpol   = 1'b0;
        quiet_window("R3", 10, 0);

        // R4: disabled core holds sclk low and ignores run
        enable = 1'b0;
        cpol   = 1'b1;
        run    = 1'b1;
        law_sel   = 1'b1;
        div_field = 8'd0;
        quiet_window("R4", 20, 0);

        // R4: disabling mid-run stops at once
        run_cfg("R2", 1'b1, 8'd2, 1'b1, 3);
        enable = 1'b0;
        quiet_window("R4", 20, 0);

        // R1: power-of-two law sweep, upper bits varied
        for (int k = 0; k < 12; k++) begin
            logic [7:0] f;
            f = 8'(k) | ((k % 3 == 1) ? 8'hA0 : (k % 3 == 2) ? 8'h50 : 8'h00);
            run_cfg("R1", 1'b0, f, 1'(k % 2), 1 << k);
        end

        // R2: linear law sweep
        for (int k = 0; k < 40; k++) begin
            run_cfg("R2", 1'b1, 8'(k), 1'(k % 2), k + 1);
        end
        run_cfg("R2", 1'b1, 8'd200, 1'b0, 201);
        run_cfg("R2", 1'b1, 8'd255, 1'b1, 256);

        // R6: drop run during the non-idle half
        run_cfg("R2", 1'b1, 8'd5, 1'b0, 6);
        wait_strobe(1'b0, 20, n);
        run = 1'b0;
        wait_strobe(1'b1, 20, n);
        @(negedge clk);
        run = 1'b1;
        wait_strobe(1'b1, 20, n);
        run = 1'b0;
        wait_strobe(1'b0, 20, n);
        check_eq("R6", "half finished after run drop", n, 6);
        check_eq("R6", "sclk idle after stop", int'(sclk), 0);
        quiet_window("R6", 30, 0);

        // R6: drop run during the idle half
        run_cfg("R2", 1'b1, 8'd4, 1'b1, 5);
        wait_strobe(1'b0, 20, n);
        run = 1'b0;
        quiet_window("R6", 30, 1);

        // R7: divider change mid-period lands at next reload
        run_cfg("R2", 1'b1, 8'd3, 1'b0, 4);
        div_field = 8'd9;
        wait_strobe(1'b0, 40, n);
        check_eq("R7", "half in flight keeps old length", n, 4);
        wait_strobe(1'b1, 40, n);
        check_eq("R7", "next half uses new length", n, 10);

        // R7: law change mid-period
        run_cfg("R1", 1'b0, 8'd2, 1'b1, 4);
        law_sel   = 1'b1;
        div_field = 8'd1;
        wait_strobe(1'b0, 40, n);
        check_eq("R7", "law change keeps old half", n, 4);
        wait_strobe(1'b1, 40, n);
        check_eq("R7", "law change new half", n, 2);

        go_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule